// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block is the control state machine that walks a device through a request to change its lifecycle state. After reset it settles in an idle state. When a transition is requested it steps through a fixed chain of phases: clock switch-over, counter increment, counter programming, a validity check of the requested move, token hashing, a flash wipe phase, two token comparisons and finally programming of the new state. The hashing engine, the non-volatile programming logic and the token store sit outside the block. Each phase talks to them through one shared pair of handshake inputs, one for step complete and one for step failed. The present phase can be read on a compact state code output.

A failing phase leaves the chain at once and lands in a sticky post-transition state, where an error is reported. A completed programming phase lands in the same state but reports success. If the current lifecycle state is already scrapped, idle goes straight to a sticky scrap state. There are two redundant escalation inputs. Either one drives the machine into a terminal escalate state from anywhere except scrap. The state register uses a sparse encoding. Any value outside the legal set is trapped into an invalid state, which then escalates.

Top module: `lc_xition_fsm`

## Requirements
- R1: While reset is low, state_o reads 0 (reset) and ack_o, busy_o, done_o and err_o are all 0. On the first clock after reset is released, with no escalation, the state moves to 1 (idle).
- R2: In idle (1), with req_i high and scrapped_i and both escalation inputs low, ack_o is high in that same cycle and the next state is 2 (clock switch).
- R3: In any working phase (codes 2 to 10), when step_done_i and step_err_i are both low, the state holds, for as many cycles as needed. This includes the second token compare (9).
- R4: When step_done_i is high and step_err_i is low, the working phases advance one code per clock in this order: clock switch 2, counter increment 3, counter program 4, validity check 5, token hash 6, flash wipe 7, token compare A 8, token compare B 9, state program 10.
- R5: When step_err_i is high, codes 3, 4, 5, 6, 8, 9 and 10 go to post-transition (11) on the next clock with err_o high, whatever step_done_i is. Codes 2 and 7 ignore step_err_i: with step_done_i low they hold, and with it high they advance.
- R6: State program (10) with step_done_i high and step_err_i low goes to 11 with done_o high and err_o low.
- R7: In idle, scrapped_i high moves the state to 12 (scrap) even when req_i is also high. ack_o stays low, and done_o and err_o are high in scrap.
- R8: If either escalation input is high, the next state is 13 (escalate) from every state except 12. This takes priority over every step input. In 13, done_o and err_o are high.
- R9: States 11, 12 and 13 are sticky. Only reset leaves 12 and 13. Only reset or escalation leaves 11.
- R10: A state register value outside the legal set reads as 14 (invalid) with err_o high. On the next clock it becomes invalid, and the clock after that it becomes escalate (13).
- R11: busy_o is high exactly in codes 2 to 10. done_o is low outside 11 to 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transition request, sampled in idle |
| scrapped_i | input | 1 | Current lifecycle state is already scrapped |
| step_done_i | input | 1 | Present phase completed |
| step_err_i | input | 1 | Present phase failed |
| esc0_i | input | 1 | Escalation input, first copy |
| esc1_i | input | 1 | Escalation input, second copy |
| ack_o | output | 1 | Request accepted this cycle |
| busy_o | output | 1 | A working phase is active |
| done_o | output | 1 | Sitting in a terminal state |
| err_o | output | 1 | Terminal or invalid state with failure |
| state_o | output | 4 | Compact state code (0 to 14) |

## Verification
Escalation and the step handshake can act in the same cycle. So can the scrapped indication and a request in idle. The bench drives an escalation input in the same cycle as step_err_i in a phase that has an error exit, and again in the same cycle as step_done_i. It also raises scrapped_i together with req_i. In each case the cycle-accurate reference model decides the winner: escalate must beat the post-transition exit, and scrap must beat the request with no acknowledge. A long random phase with sparse escalation pulses then repeats these collisions in many other states.

// File: rtl/lc_xition_fsm.sv
module lc_xition_fsm (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       scrapped_i,
  input  logic       step_done_i,
  input  logic       step_err_i,
  input  logic       esc0_i,
  input  logic       esc1_i,
  output logic       ack_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [3:0] state_o
);
  localparam int SW = 10;
  localparam logic [SW-1:0] S_RESET  = 10'h163;
  localparam logic [SW-1:0] S_IDLE   = 10'h2B5;
  localparam logic [SW-1:0] S_CLKSW  = 10'h0DA;
  localparam logic [SW-1:0] S_INCR   = 10'h34C;
  localparam logic [SW-1:0] S_CPROG  = 10'h1E9;
  localparam logic [SW-1:0] S_VCHK   = 10'h27E;
  localparam logic [SW-1:0] S_HASH   = 10'h09F;
  localparam logic [SW-1:0] S_WIPE   = 10'h3A1;
  localparam logic [SW-1:0] S_TCMPA  = 10'h156;
  localparam logic [SW-1:0] S_TCMPB  = 10'h2C8;
  localparam logic [SW-1:0] S_SPROG  = 10'h07B;
  localparam logic [SW-1:0] S_POST   = 10'h31D;
  localparam logic [SW-1:0] S_SCRAP  = 10'h1B0;
  localparam logic [SW-1:0] S_ESC    = 10'h26F;
  localparam logic [SW-1:0] S_INVAL  = 10'h0C4;

  logic [SW-1:0] state_q, state_d;
  logic          ok_q, ok_d;
  logic          esc_any;

  assign esc_any = esc0_i | esc1_i;

  always_comb begin
    state_d = state_q;
    ok_d    = ok_q;
    case (state_q)
      S_RESET: state_d = S_IDLE;
      S_IDLE: begin
        if (scrapped_i)  state_d = S_SCRAP;
        else if (req_i)  state_d = S_CLKSW;
      end
      S_CLKSW: if (step_done_i) state_d = S_INCR;
      S_INCR: begin
        if (step_err_i)       state_d = S_POST;
        else if (step_done_i) state_d = S_CPROG;
      end
      S_CPROG: begin
        if (step_err_i)       state_d = S_POST;
        else if (step_done_i) state_d = S_VCHK;
      end
      S_VCHK: begin
        if (step_err_i)       state_d = S_POST;
        else if (step_done_i) state_d = S_HASH;
      end
      S_HASH: begin
        if (step_err_i)       state_d = S_POST;
        else if (step_done_i) state_d = S_WIPE;
      end
      S_WIPE: if (step_done_i) state_d = S_TCMPA;
      S_TCMPA: begin
        if (step_err_i)       state_d = S_POST;
        else if (step_done_i) state_d = S_TCMPB;
      end
      S_TCMPB: begin
        if (step_err_i)       state_d = S_POST;
        else if (step_done_i) state_d = S_SPROG;
      end
      S_SPROG: begin
        if (step_err_i) state_d = S_POST;
        else if (step_done_i) begin
          state_d = S_POST;
          ok_d    = 1'b1;
        end
      end
      S_POST, S_SCRAP, S_ESC: state_d = state_q;
      S_INVAL: state_d = S_ESC;
      default: state_d = S_INVAL;
    endcase
    if (esc_any && state_q != S_SCRAP) state_d = S_ESC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_RESET;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ok_q    <= ok_d;
    end
  end

  always_comb begin
    case (state_q)
      S_RESET: state_o = 4'd0;
      S_IDLE:  state_o = 4'd1;
      S_CLKSW: state_o = 4'd2;
      S_INCR:  state_o = 4'd3;
      S_CPROG: state_o = 4'd4;
      S_VCHK:  state_o = 4'd5;
      S_HASH:  state_o = 4'd6;
      S_WIPE:  state_o = 4'd7;
      S_TCMPA: state_o = 4'd8;
      S_TCMPB: state_o = 4'd9;
      S_SPROG: state_o = 4'd10;
      S_POST:  state_o = 4'd11;
      S_SCRAP: state_o = 4'd12;
      S_ESC:   state_o = 4'd13;
      default: state_o = 4'd14;
    endcase
  end

  assign ack_o  = (state_q == S_IDLE) & req_i & ~scrapped_i & ~esc_any;
  assign busy_o = (state_o >= 4'd2) && (state_o <= 4'd10);
  assign done_o = (state_q == S_POST) | (state_q == S_SCRAP) | (state_q == S_ESC);
  assign err_o  = (state_q == S_SCRAP) | (state_q == S_ESC) | (state_o == 4'd14) |
                  ((state_q == S_POST) & ~ok_q);
endmodule

module lc_xition_fsm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       scrapped_i,
  input logic       step_done_i,
  input logic       step_err_i,
  input logic       esc0_i,
  input logic       esc1_i,
  input logic       ack_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic [3:0] state_o
);
  assert_reset_to_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd0 && !esc0_i && !esc1_i) |=> state_o == 4'd1);

  assert_ack_starts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> state_o == 4'd2);

  assert_phase_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !step_done_i && !step_err_i && !esc0_i && !esc1_i) |=> $stable(state_o));

  assert_pass_report_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && !err_o) |-> $past(state_o) == 4'd10);

  assert_escalate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((esc0_i || esc1_i) && state_o != 4'd12) |=> state_o == 4'd13);

  assert_esc_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 4'd13 |=> state_o == 4'd13);

  assert_scrap_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 4'd12 |=> state_o == 4'd12);

  assert_invalid_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 4'd14 |=> (state_o == 4'd14 || state_o == 4'd13));
endmodule

bind lc_xition_fsm lc_xition_fsm_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .scrapped_i(scrapped_i),
  .step_done_i(step_done_i), .step_err_i(step_err_i), .esc0_i(esc0_i),
  .esc1_i(esc1_i), .ack_o(ack_o), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .state_o(state_o)
);

// File: tb/lc_xition_fsm_test.sv
module lc_xition_fsm_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, scr = 0, sdone = 0, serr = 0, e0 = 0, e1 = 0;
  logic ack, busy, done, err;
  logic [3:0] st_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;
  string cur_req = "R1";

  int m_st = 0;
  bit m_ok = 0;
  bit hold = 0;

  always #4 clk = ~clk;

  lc_xition_fsm uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .scrapped_i(scr),
    .step_done_i(sdone), .step_err_i(serr), .esc0_i(e0), .esc1_i(e1),
    .ack_o(ack), .busy_o(busy), .done_o(done), .err_o(err), .state_o(st_o)
  );

  function automatic bit can_fail(int s);
    return s == 3 || s == 4 || s == 5 || s == 6 || s == 8 || s == 9 || s == 10;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0;
      m_ok = 0;
    end else if (!hold) begin
      if ((e0 || e1) && m_st != 12) m_st = 13;
      else if (m_st == 0) m_st = 1;
      else if (m_st == 1) begin
        if (scr) m_st = 12;
        else if (req) m_st = 2;
      end else if (m_st >= 2 && m_st <= 10) begin
        if (serr && can_fail(m_st)) m_st = 11;
        else if (sdone) begin
          if (m_st == 10) begin m_st = 11; m_ok = 1; end
          else m_st = m_st + 1;
        end
      end else if (m_st == 14) m_st = 13;
      else if (m_st == 15) m_st = 14;
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      int es;
      bit ed, ee, eb, ea;
      es = (m_st == 15) ? 14 : m_st;
      ed = (m_st == 11 || m_st == 12 || m_st == 13);
      ee = (m_st >= 12) || (m_st == 11 && !m_ok);
      eb = (m_st >= 2 && m_st <= 10);
      ea = rst_n && m_st == 1 && req && !scr && !e0 && !e1;
      chk(cur_req, "state", int'(st_o), es);
      chk(cur_req, "done", int'(done), int'(ed));
      chk(cur_req, "err", int'(err), int'(ee));
      chk("R11", "busy", int'(busy), int'(eb));
      chk("R2", "ack", int'(ack), int'(ea));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic setin(bit r, bit s, bit d, bit f, bit a, bit b);
    @(negedge clk);
    #1;
    req = r; scr = s; sdone = d; serr = f; e0 = a; e1 = b;
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1;
    rst_n = 0;
    req = 0; scr = 0; sdone = 0; serr = 0; e0 = 0; e1 = 0;
    repeat (2) @(negedge clk);
    #1;
    rst_n = 1;
  endtask

  task automatic run_to(int k);
    setin(1, 0, 0, 0, 0, 0);
    while (m_st < 2) setin(1, 0, 0, 0, 0, 0);
    while (m_st < k) setin(0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    cur_req = "R1";
    do_reset();
    repeat (3) setin(0, 0, 0, 0, 0, 0);

    cur_req = "R4";
    run_to(2);
    for (int k = 2; k <= 10; k++) begin
      cur_req = "R3";
      repeat (k == 9 ? 4 : 1) setin(0, 0, 0, 0, 0, 0);
      cur_req = "R4";
      setin(0, 0, 1, 0, 0, 0);
    end
    cur_req = "R6";
    repeat (2) setin(0, 0, 0, 0, 0, 0);
    cur_req = "R9";
    repeat (4) setin(1, 1, 1, 1, 0, 0);

    for (int k = 2; k <= 10; k++) begin
      cur_req = "R1";
      do_reset();
      cur_req = "R5";
      run_to(k);
      setin(0, 0, 0, 1, 0, 0);
      setin(0, 0, 0, 1, 0, 0);
      setin(0, 0, 1, 1, 0, 0);
      repeat (2) setin(0, 0, 0, 0, 0, 0);
    end

    cur_req = "R7";
    do_reset();
    setin(1, 1, 0, 0, 0, 0);
    cur_req = "R9";
    repeat (3) setin(1, 1, 1, 0, 1, 1);

    cur_req = "R8";
    do_reset();
    run_to(5);
    setin(0, 0, 0, 1, 1, 0);
    repeat (2) setin(1, 0, 1, 0, 0, 0);
    do_reset();
    run_to(8);
    setin(0, 0, 1, 0, 0, 1);
    setin(0, 0, 0, 0, 0, 0);
    do_reset();
    run_to(10);
    setin(0, 0, 0, 1, 0, 0);
    setin(0, 0, 0, 0, 0, 1);
    repeat (2) setin(0, 0, 0, 0, 0, 0);

    cur_req = "R10";
    do_reset();
    run_to(4);
    setin(0, 0, 0, 0, 0, 0);
    force uut.state_q = 10'h000;
    m_st = 15;
    hold = 1;
    @(posedge clk);
    #1;
    release uut.state_q;
    hold = 0;
    repeat (4) setin(0, 0, 1, 1, 0, 0);

    cur_req = "R8";
    for (int i = 0; i < 4000; i++) begin
      if (i % 150 == 0) do_reset();
      setin(($urandom % 3) == 0, ($urandom % 40) == 0, ($urandom % 2) == 0,
            ($urandom % 10) == 0, ($urandom % 120) == 0, ($urandom % 120) == 0);
    end

    setin(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule